// File: doc/BRIEF.md
# Pipelined base-2 logarithm unit

This unit turns a positive number into an approximate base-2 logarithm, given as a signed fixed-point code with 8 integer bits and 8 fraction bits. Each operand comes with a mode flag. The operand is read either as a 32-bit single-precision float or as an unsigned fixed-point word with 16 fraction bits.

For a float, the integer part of the result comes straight from the unbiased exponent. For a fixed-point word, a leading-one search supplies the integer part, and a left shift then puts the leading one at the top of the word. In both modes, the four bits just below the leading one select one entry of a sixteen-entry table, and that entry is the fraction. The unit has no multipliers and no iteration.

The datapath has three register stages and takes one operand on every clock. Each operand is classified in the first stage into one of four classes:

- `CLS_FINITE`: an ordinary positive value.
- `CLS_ZERO`: a zero or a denormal.
- `CLS_INVALID`: a negative value or a NaN.
- `CLS_POSINF`: positive infinity.

The class travels with the data. The last stage uses it to choose the result code. The stages are:

1. Decode and leading-one search.
2. Normalising shift.
3. Table lookup and assembly.

A valid bit moves alongside each stage. There are no control states beyond these class tags.

Top module: `log2u_top`

## Requirements
- R1: The unit accepts one operand on every clock. `out_valid` is high exactly on the third rising edge after the edge that sampled `in_valid`=1, and results leave in arrival order. While `in_valid` is 0, `in_data` and `in_fixed` produce no output.
- R2: With `in_fixed`=0, `in_data` is a single-precision float: sign in bit 31, biased exponent in bits 30:23 (bias 127), mantissa in bits 22:0. For a positive normal value, `out_res[15:8]` is the two's-complement value exponent-127 and `out_err` is 0.
- R3: `out_res[7:0]` is table entry k, where k is the four bits just below the leading one. Entry k is round(256*log2(1+(k+0.5)/16)). The whole signed code divided by 256 lies within 14/256 of the true log2.
- R4: With `in_fixed`=1, `in_data` is unsigned with 16 fraction bits. For a nonzero word, `out_res[15:8]` is the index of the highest set bit minus 16, and `out_err` is 0.
- R5: The following inputs give `out_res`=16'h8000 with `out_err`=1: a fixed-point zero, or a float whose exponent field is 0 (either sign of zero, or any denormal).
- R6: A float with exponent field 255 and a nonzero mantissa (NaN, either sign) gives `out_res`=16'h0000 with `out_err`=1.
- R7: A float with the sign bit set and a nonzero exponent field that is not a NaN gives `out_res`=16'h0000 with `out_err`=1. This covers negative normals and negative infinity.
- R8: Positive infinity (16'h7F80 in the upper half, mantissa 0) gives `out_res`=16'h7FFF with `out_err`=0.
- R9: A synchronous active-high `rst` clears every valid bit. Operands presented while `rst` is high produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand present this cycle |
| in_fixed | input | 1 | 1: unsigned fixed-point with 16 fraction bits; 0: single-precision float |
| in_data | input | 32 | Operand |
| out_valid | output | 1 | Result present this cycle |
| out_res | output | 16 | Signed log2 result, 8 integer and 8 fraction bits |
| out_err | output | 1 | Input was zero, denormal, negative or NaN |

## Verification
The bench checks the corner cases where each class tag must win over the ordinary path:

- **Negative zero:** must classify as zero, not as negative. A design that tested the sign first would return 0 instead of 16'h8000.
- **Negative infinity and sign-set NaNs:** must yield 0 with the error flag. Confusing infinity with NaN would instead saturate or clear the error flag.
- **Fixed-point words at both ends:** a single LSB must give integer -16 and an all-ones word must give integer 15. An off-by-one leading-one index or shift would move the result by a whole unit or pick the wrong table entry, which the 14/256 tolerance exposes.
- **Idle cycles and reset:** operands under reset and gaps carrying garbage data show whether a valid bit leaks or is lost, since a wrong latency shifts every comparison by a cycle.

// File: rtl/log2u_pkg.sv
package log2u_pkg;

    localparam int FLT_W      = 32;
    localparam int FLT_MAN_W  = 23;
    localparam int FLT_EXP_W  = 8;
    localparam int FLT_BIAS   = 127;
    localparam int IDX_W      = 4;
    localparam int LUT_W      = 8;

    typedef enum logic [1:0] {
        CLS_FINITE  = 2'd0,
        CLS_ZERO    = 2'd1,
        CLS_INVALID = 2'd2,
        CLS_POSINF  = 2'd3
    } log2u_cls_e;

    // Midpoint table: round(256*log2(1+(k+0.5)/16))
    function automatic logic [LUT_W-1:0] frac_lut(input logic [IDX_W-1:0] k);
        logic [LUT_W-1:0] r;
        unique case (k)
            4'd0:  r = 8'd11;
            4'd1:  r = 8'd33;
            4'd2:  r = 8'd54;
            4'd3:  r = 8'd73;
            4'd4:  r = 8'd92;
            4'd5:  r = 8'd109;
            4'd6:  r = 8'd126;
            4'd7:  r = 8'd142;
            4'd8:  r = 8'd157;
            4'd9:  r = 8'd172;
            4'd10: r = 8'd186;
            4'd11: r = 8'd200;
            4'd12: r = 8'd213;
            4'd13: r = 8'd226;
            4'd14: r = 8'd238;
            4'd15: r = 8'd250;
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/log2u_decode.sv
module log2u_decode
    import log2u_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int FIX_FRAC = 16,
    parameter int INT_W    = 8,
    localparam int SH_W    = $clog2(DATA_W)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic                    in_fixed,
    input  logic [DATA_W-1:0]       in_data,
    output logic                    s1_valid,
    output log2u_cls_e              s1_cls,
    output logic signed [INT_W-1:0] s1_int,
    output logic [DATA_W-1:0]       s1_mag,
    output logic [SH_W-1:0]         s1_shamt
);

    localparam int PAD_W = DATA_W - FLT_MAN_W - 1;

    logic                 f_sign;
    logic [FLT_EXP_W-1:0] f_exp;
    logic [FLT_MAN_W-1:0] f_man;
    logic [SH_W-1:0]      lead;

    log2u_cls_e              cls_d;
    logic signed [INT_W-1:0] int_d;
    logic [DATA_W-1:0]       mag_d;
    logic [SH_W-1:0]         sh_d;

    assign f_sign = in_data[FLT_W-1];
    assign f_exp  = in_data[FLT_W-2 -: FLT_EXP_W];
    assign f_man  = in_data[FLT_MAN_W-1:0];

    always_comb begin
        lead = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (in_data[i]) lead = SH_W'(i);
        end
    end

    always_comb begin
        cls_d = CLS_FINITE;
        int_d = '0;
        mag_d = '0;
        sh_d  = '0;
        if (in_fixed) begin
            cls_d = (in_data == '0) ? CLS_ZERO : CLS_FINITE;
            int_d = INT_W'(int'(lead) - FIX_FRAC);
            mag_d = in_data;
            sh_d  = SH_W'(DATA_W - 1) - lead;
        end else begin
            int_d = INT_W'(int'(f_exp) - FLT_BIAS);
            mag_d = {1'b1, f_man, {PAD_W{1'b0}}};
            if (f_exp == '0)
                cls_d = CLS_ZERO;
            else if (f_exp == '1 && f_man != '0)
                cls_d = CLS_INVALID;
            else if (f_sign)
                cls_d = CLS_INVALID;
            else if (f_exp == '1)
                cls_d = CLS_POSINF;
            else
                cls_d = CLS_FINITE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s1_valid <= 1'b0;
        else     s1_valid <= in_valid;
    end

    always_ff @(posedge clk) begin
        s1_cls   <= cls_d;
        s1_int   <= int_d;
        s1_mag   <= mag_d;
        s1_shamt <= sh_d;
    end

    AST_FIX_NONZERO_FINITE: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_fixed && in_data != '0 |=> s1_valid && s1_cls == CLS_FINITE); // R4
    AST_FLT_ZERO_EXP: assert property (@(posedge clk) disable iff (rst)
        in_valid && !in_fixed && in_data[FLT_W-2 -: FLT_EXP_W] == '0 |=> s1_cls == CLS_ZERO); // R5

endmodule

// File: rtl/log2u_norm.sv
module log2u_norm
    import log2u_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int INT_W    = 8,
    localparam int SH_W    = $clog2(DATA_W),
    localparam int TOP_W   = IDX_W + 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    s1_valid,
    input  log2u_cls_e              s1_cls,
    input  logic signed [INT_W-1:0] s1_int,
    input  logic [DATA_W-1:0]       s1_mag,
    input  logic [SH_W-1:0]         s1_shamt,
    output logic                    s2_valid,
    output log2u_cls_e              s2_cls,
    output logic signed [INT_W-1:0] s2_int,
    output logic [IDX_W-1:0]        s2_idx
);

    logic [TOP_W-1:0] top_w;

    // leading one plus the IDX_W bits beneath it after alignment
    assign top_w = TOP_W'((s1_mag << s1_shamt) >> (DATA_W - TOP_W));

    always_ff @(posedge clk) begin
        if (rst) s2_valid <= 1'b0;
        else     s2_valid <= s1_valid;
    end

    always_ff @(posedge clk) begin
        s2_cls <= s1_cls;
        s2_int <= s1_int;
        s2_idx <= top_w[IDX_W-1:0];
    end

    AST_ALIGNED_LEAD: assert property (@(posedge clk) disable iff (rst)
        s1_valid && s1_cls == CLS_FINITE |-> top_w[IDX_W]); // R3

endmodule

// File: rtl/log2u_assemble.sv
module log2u_assemble
    import log2u_pkg::*;
#(
    parameter int INT_W    = 8,
    localparam int RES_W   = INT_W + LUT_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    s2_valid,
    input  log2u_cls_e              s2_cls,
    input  logic signed [INT_W-1:0] s2_int,
    input  logic [IDX_W-1:0]        s2_idx,
    output logic                    out_valid,
    output logic [RES_W-1:0]        out_res,
    output logic                    out_err
);

    localparam logic [RES_W-1:0] RES_MIN = {1'b1, {(RES_W-1){1'b0}}};
    localparam logic [RES_W-1:0] RES_MAX = {1'b0, {(RES_W-1){1'b1}}};

    logic [RES_W-1:0] res_d;
    logic             err_d;

    always_comb begin
        res_d = '0;
        err_d = 1'b0;
        unique case (s2_cls)
            CLS_FINITE:  res_d = {s2_int, frac_lut(s2_idx)};
            CLS_ZERO:    begin res_d = RES_MIN; err_d = 1'b1; end
            CLS_INVALID: begin res_d = '0;      err_d = 1'b1; end
            CLS_POSINF:  res_d = RES_MAX;
            default:     res_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) out_valid <= 1'b0;
        else     out_valid <= s2_valid;
    end

    always_ff @(posedge clk) begin
        out_res <= res_d;
        out_err <= err_d;
    end

    AST_ZERO_TO_MIN: assert property (@(posedge clk) disable iff (rst)
        s2_valid && s2_cls == CLS_ZERO |=> out_valid && out_err && out_res == RES_MIN); // R5
    AST_INVALID_TO_NULL: assert property (@(posedge clk) disable iff (rst)
        s2_valid && s2_cls == CLS_INVALID |=> out_valid && out_err && out_res == '0); // R6
    AST_INF_TO_MAX: assert property (@(posedge clk) disable iff (rst)
        s2_valid && s2_cls == CLS_POSINF |=> out_valid && !out_err && out_res == RES_MAX); // R8

endmodule

// File: rtl/log2u_top.sv
module log2u_top
    import log2u_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int FIX_FRAC = 16,
    parameter int INT_W    = 8,
    localparam int SH_W    = $clog2(DATA_W),
    localparam int RES_W   = INT_W + LUT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_fixed,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [RES_W-1:0]  out_res,
    output logic              out_err
);

    logic                    s1_valid;
    log2u_cls_e              s1_cls;
    logic signed [INT_W-1:0] s1_int;
    logic [DATA_W-1:0]       s1_mag;
    logic [SH_W-1:0]         s1_shamt;

    logic                    s2_valid;
    log2u_cls_e              s2_cls;
    logic signed [INT_W-1:0] s2_int;
    logic [IDX_W-1:0]        s2_idx;

    log2u_decode #(.DATA_W(DATA_W), .FIX_FRAC(FIX_FRAC), .INT_W(INT_W)) u_decode (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_fixed(in_fixed), .in_data(in_data),
        .s1_valid(s1_valid), .s1_cls(s1_cls), .s1_int(s1_int), .s1_mag(s1_mag),
        .s1_shamt(s1_shamt)
    );

    log2u_norm #(.DATA_W(DATA_W), .INT_W(INT_W)) u_norm (
        .clk(clk), .rst(rst), .s1_valid(s1_valid), .s1_cls(s1_cls), .s1_int(s1_int),
        .s1_mag(s1_mag), .s1_shamt(s1_shamt), .s2_valid(s2_valid), .s2_cls(s2_cls),
        .s2_int(s2_int), .s2_idx(s2_idx)
    );

    log2u_assemble #(.INT_W(INT_W)) u_assemble (
        .clk(clk), .rst(rst), .s2_valid(s2_valid), .s2_cls(s2_cls), .s2_int(s2_int),
        .s2_idx(s2_idx), .out_valid(out_valid), .out_res(out_res), .out_err(out_err)
    );

    // cycles since reset, saturating, so the latency check never looks before reset
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                  since_rst <= '0;
        else if (since_rst != '1) since_rst <= since_rst + 2'd1;
    end

    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst)
        since_rst == '1 |-> out_valid == $past(in_valid, 3)); // R1
    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> !out_valid); // R9

endmodule

// File: tb/tb_log2u_top.sv
`timescale 1ns/1ps
module tb_log2u_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_fixed = 1'b0;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic [15:0] out_res;
    logic        out_err;

    int total = 0;
    int bad = 0;
    int pc = 0;
    int lcg = 12345;
    localparam real TOL = 14.0 / 256.0;

    typedef struct {
        int         due;
        bit         exact;
        logic [15:0] code;
        logic       err;
        real        ideal;
        string      tag;
    } exp_t;

    exp_t q[$];

    log2u_top dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_fixed(in_fixed), .in_data(in_data),
        .out_valid(out_valid), .out_res(out_res), .out_err(out_err)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) pc <= pc + 1;

    task automatic chk(bit ok, string tag, string act, string exp_s);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%s expected=%s", tag, act, exp_s);
        end
    endtask

    function automatic exp_t model(logic fx, logic [31:0] d);
        exp_t e;
        int ex;
        e.exact = 1'b1; e.code = '0; e.err = 1'b1; e.ideal = 0.0; e.due = 0;
        ex = int'(d[30:23]);
        if (fx) begin
            if (d == 0) begin e.code = 16'h8000; e.tag = "R5 fixed zero"; end
            else begin
                e.exact = 1'b0; e.err = 1'b0; e.tag = "R4 R3 fixed";
                e.ideal = $ln(real'(longint'(d))) / $ln(2.0) - 16.0;
            end
        end else if (ex == 0) begin
            e.code = 16'h8000; e.tag = "R5 float zero/denormal";
        end else if (ex == 255 && d[22:0] != 0) begin
            e.code = 16'h0000; e.tag = "R6 NaN";
        end else if (d[31]) begin
            e.code = 16'h0000; e.tag = "R7 negative";
        end else if (ex == 255) begin
            e.code = 16'h7FFF; e.err = 1'b0; e.tag = "R8 +inf";
        end else begin
            e.exact = 1'b0; e.err = 1'b0; e.tag = "R2 R3 float";
            e.ideal = real'(ex - 127) +
                      $ln(1.0 + real'(int'(d[22:0])) / 8388608.0) / $ln(2.0);
        end
        return e;
    endfunction

    task automatic check_out();
        if (q.size() > 0 && q[0].due == pc) begin
            exp_t e = q.pop_front();
            chk(out_valid === 1'b1, "R1 valid expected", $sformatf("%b", out_valid), "1");
            if (e.exact) begin
                chk(out_res === e.code && out_err === e.err, e.tag,
                    $sformatf("%h/%b", out_res, out_err), $sformatf("%h/%b", e.code, e.err));
            end else begin
                real got = real'($signed(out_res)) / 256.0;
                real diff = got - e.ideal;
                if (diff < 0.0) diff = -diff;
                chk(diff <= TOL && out_err === 1'b0, e.tag,
                    $sformatf("%f/%b", got, out_err), $sformatf("%f/0", e.ideal));
            end
        end else begin
            chk(out_valid === 1'b0, "R1 no output", $sformatf("%b", out_valid), "0");
        end
    endtask

    task automatic step(bit v, bit fx, logic [31:0] d);
        @(negedge clk);
        check_out();
        in_valid = v;
        in_fixed = fx;
        in_data  = d;
        if (v) begin
            exp_t e = model(fx, d);
            e.due = pc + 3;
            q.push_back(e);
        end
    endtask

    function automatic int next_rand();
        lcg = lcg * 1103515245 + 12345;
        return lcg;
    endfunction

    initial begin
        // R9: operands under reset are dropped
        in_valid = 1'b1; in_data = 32'h3F80_0000;
        repeat (4) @(negedge clk);
        chk(out_valid === 1'b0, "R9 reset clears valid", $sformatf("%b", out_valid), "0");
        rst = 1'b0; in_valid = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(out_valid === 1'b0, "R9 after reset", $sformatf("%b", out_valid), "0");
        end
        // float directed
        step(1, 0, 32'h3F80_0000);  // 1.0
        step(1, 0, 32'h4000_0000);  // 2.0
        step(1, 0, 32'h4040_0000);  // 3.0
        step(1, 0, 32'h3F40_0000);  // 0.75
        step(0, 1, 32'hDEAD_BEEF);  // R1 idle garbage ignored
        step(1, 0, 32'h4120_0000);  // 10.0
        step(1, 0, 32'h7F7F_FFFF);  // max normal
        step(1, 0, 32'h0080_0000);  // min normal
        step(1, 0, 32'h0000_0000);  // +0 R5
        step(1, 0, 32'h8000_0000);  // -0 R5
        step(1, 0, 32'h0000_0001);  // denormal R5
        step(1, 0, 32'h7FC0_0000);  // NaN R6
        step(1, 0, 32'hFF80_0001);  // negative NaN R6
        step(1, 0, 32'hC000_0000);  // -2.0 R7
        step(1, 0, 32'hFF80_0000);  // -inf R7
        step(1, 0, 32'h7F80_0000);  // +inf R8
        // fixed directed
        step(1, 1, 32'h0001_0000);  // 1.0
        step(1, 1, 32'h0000_0001);  // -16
        step(1, 1, 32'hFFFF_FFFF);  // near 16
        step(1, 1, 32'h0003_0000);  // 3.0
        step(1, 1, 32'h0000_8000);  // 0.5
        step(1, 1, 32'h0000_0000);  // R5 fixed zero
        step(0, 0, 32'h7F80_0000);
        step(0, 1, 32'h0000_0000);
        // mixed stream with gaps
        for (int i = 0; i < 400; i++) begin
            int r1 = next_rand();
            int r2 = next_rand();
            int r3 = next_rand();
            step(r1[20:18] != 3'd0, r1[25], {r2[31:16], r3[31:16]});
        end
        for (int i = 0; i < 6; i++) step(0, 0, 32'h0);
        chk(q.size() == 0, "R1 all results delivered", $sformatf("%0d", q.size()), "0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule